// File: doc/BRIEF.md
# Reciprocal Multiply Unit

This unit scales a 64-bit destination operand by a fixed-point reciprocal of a 32-bit immediate. The immediate is read as an unsigned number. The reciprocal is `floor(2^x / imm)`, where `x` is the largest exponent that still keeps the quotient below 2^64. For an immediate whose highest set bit is at position `k`, that exponent is `64 + k`. The unit multiplies the destination by the reciprocal and returns only the low 64 bits of the product.

A zero immediate, or an immediate that is an exact power of two, makes the operation a pass-through: the destination comes back unchanged one cycle after the start strobe. For every other immediate, a restoring divider produces one quotient bit per clock. A single-cycle multiply step follows the divider. Only one operation runs at a time. A start strobe that arrives while an operation is in progress is dropped.

Top module: `rcp_mul_unit`

## Requirements
- R1: With `imm_i` = 0, `result_o` equals `dst_i` when `done_o` pulses.
- R2: With `imm_i` an exact power of two (1, 2, ..., 2^31), `result_o` equals `dst_i` when `done_o` pulses.
- R3: `imm_i` is treated as unsigned and zero-extended. For any other immediate whose top set bit is at position k, the reciprocal is floor(2^(64+k) / imm_i). This value always lies in [2^63, 2^64).
- R4: In the non-trivial case, `result_o` = (`dst_i` × reciprocal) mod 2^64, using the `dst_i` sampled with the accepted start.
- R5: For a pass-through, `done_o` is high in the cycle after the start edge. Otherwise `done_o` rises DW+2 cycles after the start edge (66 with the default width).
- R6: `done_o` is high for exactly one cycle. `result_o` holds its value until the next completion.
- R7: A `start_i` asserted while an operation is in progress is ignored. The running operation finishes with its own operands, and no extra completion follows.
- R8: After reset, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; accepted only when the unit is idle |
| dst_i | input | 64 | Destination operand |
| imm_i | input | 32 | Unsigned immediate |
| result_o | output | 64 | Low 64 bits of the scaled result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default widths: a 64-bit destination and a 32-bit immediate. The full 64-step divide and its exact latency are therefore exercised. With these widths, the bench reaches both ends of the immediate range: 3, the smallest non-trivial value, and 0xFFFFFFFF, the largest. It also covers an immediate with its top bit set, which would change the result if it were sign-extended, and single-bit immediates at bit 0 and bit 31. Expected reciprocals come from a 128-bit search over every exponent, which is a different method from the bit-serial divider in the design.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_MUL  = 2'd2
  } rcp_state_e;
endpackage

// File: rtl/rcp_classify.sv
module rcp_classify #(
  parameter int IW = 32,
  localparam int KW = $clog2(IW)
) (
  input  logic [IW-1:0] imm_i,
  output logic          trivial_o,
  output logic [KW-1:0] msb_o
);
  function automatic logic [KW-1:0] top_bit(input logic [IW-1:0] v);
    logic [KW-1:0] pos;
    pos = '0;
    for (int i = 0; i < IW; i++) begin
      if (v[i]) pos = KW'(i);
    end
    return pos;
  endfunction

  function automatic logic single_or_none(input logic [IW-1:0] v);
    return (v & (v - IW'(1))) == '0;
  endfunction

  assign trivial_o = single_or_none(imm_i);
  assign msb_o     = top_bit(imm_i);
endmodule

// File: rtl/rcp_divider.sv
module rcp_divider #(
  parameter int DW = 64,
  parameter int IW = 32,
  localparam int KW = $clog2(IW),
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [IW-1:0] dvs_i,
  input  logic [KW-1:0] msb_i,
  output logic [DW-1:0] quot_o,
  output logic          fin_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] rem_q;
  logic [IW-1:0] dvs_q;
  logic [DW-1:0] quot_q;

  logic [IW:0]   rem_sh;
  logic          take;
  logic [IW:0]   rem_sub;

  function automatic logic [IW:0] shift_in_zero(input logic [IW-1:0] r);
    return {r, 1'b0};
  endfunction

  assign rem_sh  = shift_in_zero(rem_q);
  assign take    = rem_sh >= {1'b0, dvs_q};
  assign rem_sub = rem_sh - {1'b0, dvs_q};
  assign fin_o   = run_q && (cnt_q == CW'(DW - 1));
  assign quot_o  = quot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quot_q <= '0;
    end else if (load_i) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= IW'(1) << msb_i;
      dvs_q  <= dvs_i;
      quot_q <= '0;
    end else if (run_q) begin
      rem_q  <= take ? rem_sub[IW-1:0] : rem_sh[IW-1:0];
      quot_q <= {quot_q[DW-2:0], take};
      cnt_q  <= cnt_q + CW'(1);
      if (fin_o) run_q <= 1'b0;
    end
  end

  // R3: partial remainder always stays below the divisor
  p_rem_below_dvs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < dvs_q));

  // R3: the finished quotient lies in [2^63, 2^64)
  p_quot_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> quot_q[DW-1]);
endmodule

// File: rtl/rcp_mul_lo.sv
module rcp_mul_lo #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] p_o
);
  function automatic logic [DW-1:0] mul_wrap(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] p;
    p = a * b;
    return p;
  endfunction

  assign p_o = mul_wrap(a_i, b_i);
endmodule

// File: rtl/rcp_mul_unit.sv
module rcp_mul_unit
  import rcp_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 32,
  localparam int KW = $clog2(IW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dst_i,
  input  logic [IW-1:0] imm_i,
  output logic [DW-1:0] result_o,
  output logic          done_o
);
  rcp_state_e    state_q;
  logic [DW-1:0] dst_q;
  logic [DW-1:0] res_q;
  logic          done_q;

  logic          trivial;
  logic [KW-1:0] msb;
  logic          accept;
  logic          div_load;
  logic          div_fin;
  logic [DW-1:0] quot;
  logic [DW-1:0] prod;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign div_load = accept && !trivial;

  rcp_classify #(.IW(IW)) u_cls (
    .imm_i     (imm_i),
    .trivial_o (trivial),
    .msb_o     (msb)
  );

  rcp_divider #(.DW(DW), .IW(IW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (div_load),
    .dvs_i  (imm_i),
    .msb_i  (msb),
    .quot_o (quot),
    .fin_o  (div_fin)
  );

  rcp_mul_lo #(.DW(DW)) u_mul (
    .a_i (dst_q),
    .b_i (quot),
    .p_o (prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dst_q <= dst_i;
          if (trivial) begin
            res_q  <= dst_i;
            done_q <= 1'b1;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_fin) state_q <= ST_MUL;
        ST_MUL: begin
          res_q   <= prod;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;

  // R1, R2: zero or single-bit immediate passes the destination straight through
  p_trivial_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trivial) |=> (done_o && result_o == $past(dst_i)));

  // R6: completion pulse lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: result only moves together with a completion
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R5: multiply step is followed by completion in the next cycle
  p_mul_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUL) |=> done_o);

  // R7: a start during a running divide leaves the captured operand alone
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != ST_IDLE) |=> $stable(dst_q));
endmodule

// File: tb/tb_rcp_mul_unit.sv
module tb_rcp_mul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] dst_i = '0;
  logic [IW-1:0] imm_i = '0;
  logic [DW-1:0] result_o;
  logic          done_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rcp_mul_unit #(.DW(DW), .IW(IW)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .dst_i    (dst_i),
    .imm_i    (imm_i),
    .result_o (result_o),
    .done_o   (done_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: scan every exponent and keep the last quotient below 2^64
  function automatic logic [63:0] ref_recip(input logic [31:0] imm);
    logic [127:0] q;
    logic [63:0]  best;
    best = '0;
    for (int x = 0; x < 128; x++) begin
      q = (128'd1 << x) / {96'd0, imm};
      if (q < (128'd1 << 64)) best = q[63:0];
    end
    return best;
  endfunction

  function automatic logic [63:0] ref_result(input logic [63:0] d, input logic [31:0] imm);
    logic [127:0] p;
    if (imm == 0 || (imm & (imm - 1)) == 0) return d;
    p = {64'd0, d} * {64'd0, ref_recip(imm)};
    return p[63:0];
  endfunction

  // Issue one op, count edges to done, check latency, value, pulse width and hold
  task automatic run_op(input string req, input logic [63:0] d, input logic [31:0] imm,
                        input int exp_lat);
    int n;
    logic [63:0] held;
    @(negedge clk);
    dst_i = d; imm_i = imm; start_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0;
      n++;
    end while (!done_o && n < 200);
    check({req, " R5 latency"}, 128'(n), 128'(exp_lat));
    check({req, " value"}, {64'd0, result_o}, {64'd0, ref_result(d, imm)});
    held = result_o;
    @(negedge clk);
    check("R6 done one cycle", {127'd0, done_o}, 128'd0);
    check("R6 result held", {64'd0, result_o}, {64'd0, held});
  endtask

  task automatic t_reset();
    check("R8 done after reset", {127'd0, done_o}, 128'd0);
    check("R8 result after reset", {64'd0, result_o}, 128'd0);
  endtask

  task automatic t_zero_imm();
    run_op("R1 imm zero", 64'hDEAD_BEEF_0123_4567, 32'd0, 1);
  endtask

  task automatic t_pow2_imm();
    run_op("R2 imm one", 64'h1111_2222_3333_4444, 32'd1, 1);
    run_op("R2 imm 2^31", 64'hFFFF_0000_FFFF_0000, 32'h8000_0000, 1);
    run_op("R2 imm 2^12", 64'h0123_4567_89AB_CDEF, 32'h0000_1000, 1);
  endtask

  task automatic t_general();
    run_op("R3 R4 imm three", 64'h0000_0000_0000_0003, 32'd3, DW + 2);
    run_op("R4 imm five all-ones", 64'hFFFF_FFFF_FFFF_FFFF, 32'd5, DW + 2);
    run_op("R4 imm max", 64'h8765_4321_0FED_CBA9, 32'hFFFF_FFFF, DW + 2);
    run_op("R3 unsigned top bit", 64'h0000_0001_0000_0001, 32'h8000_0001, DW + 2);
    run_op("R4 imm mid", 64'h5A5A_A5A5_3C3C_C3C3, 32'h0012_3457, DW + 2);
  endtask

  task automatic t_busy_ignore();
    int n;
    int extra;
    logic [63:0] d0;
    d0 = 64'h0F0F_F0F0_1234_5678;
    @(negedge clk);
    dst_i = d0; imm_i = 32'd7; start_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start_i = (n == 10);
      if (n == 10) begin
        dst_i = 64'hAAAA_AAAA_AAAA_AAAA;
        imm_i = 32'd0;
      end
    end while (!done_o && n < 200);
    start_i = 1'b0;
    check("R7 latency unchanged", 128'(n), 128'(DW + 2));
    check("R7 first op result", {64'd0, result_o}, {64'd0, ref_result(d0, 32'd7)});
    extra = 0;
    for (int i = 0; i < DW + 10; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check("R7 no extra completion", 128'(extra), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_imm();
    t_pow2_imm();
    t_general();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule